// File: doc/BRIEF.md
# Integer Decode-Execute Unit

This unit takes one 32-bit instruction word of a small RISC processor, together with the two register values that the instruction's source fields name. It decodes the word and produces the integer result, the index of the destination register and a write strobe. It executes add, subtract, the bitwise operations, the high-half logic forms, the signed and unsigned compares, the three shifts, byte and halfword sign extension, multiply, and unsigned divide and remainder. Loads, stores, branches, calls, system calls and control-register accesses are not executed here. They are only marked for the units that handle them.

Every operation except divide and remainder completes in one registered cycle: `done` pulses in the cycle after the instruction is accepted. Divide and remainder go to an iterative divider that produces one quotient bit per cycle. While it runs, `busy` stays high and new instructions are not accepted. Four parameters enable or remove the multiplier, the divider, the sign extender and the barrel shifter. Without the shifter, the unit still accepts right shifts by exactly one bit.

Each completion reports exactly one outcome: a register write, an illegal instruction, a divide by zero, a halt request, a hand-off to another unit, or nothing (a write aimed at register 0).

Top module: `int_exec_core`

## Requirements
- R1: While reset is applied, and until the first instruction is accepted, `done`, `busy`, `wr_en`, `illegal`, `div_zero`, `halt` and `handoff` are all low.
- R2: The opcode is bits 31:26, and bit 31 set selects the register-register form. In that form the destination index is bits 15:11. Otherwise the destination is bits 20:16 and the second operand is the immediate in bits 15:0. `opa` carries the register named by bits 25:21 and `opb` the register named by bits 20:16. When the destination index is 0, `wr_en` stays low.
- R3: The following opcodes act on `opa` and the second operand: add (0x0D/0x2D), sub (0x32), and (0x08/0x28), or (0x0E/0x2E), xor (0x06/0x26), nor (0x01/0x21) and xnor (0x09/0x29). The add immediate is sign-extended; the bitwise immediates are zero-extended.
- R4: andhi (0x18) and orhi (0x1E) combine `opa` with the immediate placed in bits 31:16 and zeros in bits 15:0.
- R5: Compares give 1 or 0 in a 32-bit word: equal 0x19/0x39, not-equal 0x1F/0x3F, signed greater 0x1A/0x3A, signed greater-or-equal 0x1B/0x3B, unsigned greater 0x1D/0x3D, unsigned greater-or-equal 0x1C/0x3C. Unsigned compare immediates are zero-extended; the other compare immediates are sign-extended.
- R6: sl (0x0F/0x2F) shifts left, sr (0x05/0x25) shifts right arithmetically and sru (0x00/0x20) shifts right logically. The amount is `opb` bits 4:0 in register form and instruction bits 4:0 in immediate form.
- R7: Without the shifter, sl is illegal, and sr or sru is illegal unless its amount is exactly 1.
- R8: mul (0x02/0x22; sign-extended immediate) gives the low 32 bits of the product. sextb (0x2C) and sexth (0x37) sign-extend bits 7:0 or 15:0 of `opa`. Each of these is illegal when its feature is disabled.
- R9: divu (0x23) and modu (0x31) give the unsigned quotient or remainder of `opa` by `opb`. `done` follows acceptance by 32 cycles, and `busy` is high from the cycle after acceptance until the cycle before `done`. Instructions offered while `busy` is high are ignored.
- R10: divu or modu with `opb` equal to 0 completes in one cycle with `div_zero` set and no write. With the divider disabled, these opcodes are illegal.
- R11: Register-register opcodes 0x27, 0x2A, 0x33 and 0x35 complete with `illegal` set and no write.
- R12: Opcode 0x28 with bits 25:11 all zero completes with `halt` set and no write. Any other 0x28 is an ordinary and.
- R13: Opcodes 0x03, 0x04, 0x07, 0x0A-0x0C, 0x10-0x17, 0x24, 0x2B, 0x30, 0x34, 0x36, 0x38 and 0x3E complete with `handoff` set and no write.
- R14: Every non-divide instruction accepted when `busy` is low completes with `done` in the next cycle. Outside a `done` cycle, `wr_en` and all outcome flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction and operands are presented |
| instr | input | 32 | Instruction word |
| opa | input | 32 | Value of the register in bits 25:21 |
| opb | input | 32 | Value of the register in bits 20:16 |
| done | output | 1 | Completion pulse |
| busy | output | 1 | Divider running; issue ignored |
| result | output | 32 | Computed value, valid with `wr_en` |
| dest | output | 5 | Destination register index |
| wr_en | output | 1 | Register write request |
| illegal | output | 1 | Illegal-instruction outcome |
| div_zero | output | 1 | Divide-by-zero outcome |
| halt | output | 1 | Halt request outcome |
| handoff | output | 1 | Instruction belongs to another unit |

## Verification
The functions that collide are the end of a long divide and the acceptance of the next instruction. The divide's `done` cycle is the first cycle in which `busy` is low, so a waiting instruction is taken at the end of that same cycle. The bench provokes this by keeping `issue_valid` high with a new instruction on every cycle of a divide. A behavioural model then requires the quotient's completion at exactly 32 cycles, no completion in between, and the held instruction's completion exactly one cycle after the quotient's. A second instance with every feature removed receives the same stream and must accept each of those held instructions, since its divide opcodes are illegal and never start the divider.

// File: rtl/iexc_pkg.sv
package iexc_pkg;
  localparam int XLEN = 32;
  localparam int RIDX = 5;
  localparam int OPW  = 6;
  localparam int IMMW = 16;
  localparam int SHW  = $clog2(XLEN);

  typedef enum logic [4:0] {
    ALU_NOP, ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR, ALU_XNOR,
    ALU_SL, ALU_SR, ALU_SRU, ALU_CEQ, ALU_CNE, ALU_CGT, ALU_CGE, ALU_CGTU,
    ALU_CGEU, ALU_MUL, ALU_SEXTB, ALU_SEXTH, ALU_DIV, ALU_MOD
  } alu_op_e;

  typedef struct packed {
    alu_op_e             op;
    logic [XLEN-1:0]     opnd_b;
    logic [RIDX-1:0]     dest;
    logic                wr;
    logic                illegal;
    logic                dz;
    logic                halt;
    logic                handoff;
    logic                div;
  } dec_t;
endpackage

// File: rtl/iexc_decode.sv
module iexc_decode
  import iexc_pkg::*;
#(
  parameter bit HAS_MUL   = 1'b1,
  parameter bit HAS_DIV   = 1'b1,
  parameter bit HAS_SEXT  = 1'b1,
  parameter bit HAS_SHIFT = 1'b1
) (
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] opb,
  output dec_t            dec
);
  logic            rr;
  logic [OPW-1:0]  opc;
  logic [IMMW-1:0] imm;
  logic [XLEN-1:0] imm_sx, imm_zx, imm_hi, amt_w;
  logic [SHW-1:0]  amt;
  logic [RIDX-1:0] dst;
  logic            ill, hlt, ho, dz;
  alu_op_e         op;
  logic [XLEN-1:0] bsel;
  logic            unused_bits;

  assign unused_bits = ^instr[10:5];

  always_comb begin
    rr     = instr[XLEN-1];
    opc    = instr[XLEN-1 -: OPW];
    imm    = instr[IMMW-1:0];
    imm_sx = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
    imm_zx = {{(XLEN-IMMW){1'b0}}, imm};
    imm_hi = {imm, {(XLEN-IMMW){1'b0}}};
    amt    = rr ? opb[SHW-1:0] : instr[SHW-1:0];
    amt_w  = {{(XLEN-SHW){1'b0}}, amt};
    dst    = rr ? instr[15:11] : instr[20:16];
    op = ALU_NOP; bsel = rr ? opb : imm_sx;
    ill = 1'b0; hlt = 1'b0; ho = 1'b0; dz = 1'b0;
    case (opc)
      6'h0D, 6'h2D: op = ALU_ADD;
      6'h32:        op = ALU_SUB;
      6'h08:        begin op = ALU_AND;  bsel = imm_zx; end
      6'h28:        if (instr[25:11] == '0) hlt = 1'b1; else op = ALU_AND;
      6'h0E, 6'h2E: begin op = ALU_OR;   if (!rr) bsel = imm_zx; end
      6'h06, 6'h26: begin op = ALU_XOR;  if (!rr) bsel = imm_zx; end
      6'h01, 6'h21: begin op = ALU_NOR;  if (!rr) bsel = imm_zx; end
      6'h09, 6'h29: begin op = ALU_XNOR; if (!rr) bsel = imm_zx; end
      6'h18:        begin op = ALU_AND;  bsel = imm_hi; end
      6'h1E:        begin op = ALU_OR;   bsel = imm_hi; end
      6'h19, 6'h39: op = ALU_CEQ;
      6'h1F, 6'h3F: op = ALU_CNE;
      6'h1A, 6'h3A: op = ALU_CGT;
      6'h1B, 6'h3B: op = ALU_CGE;
      6'h1D, 6'h3D: begin op = ALU_CGTU; if (!rr) bsel = imm_zx; end
      6'h1C, 6'h3C: begin op = ALU_CGEU; if (!rr) bsel = imm_zx; end
      6'h0F, 6'h2F: begin op = ALU_SL;  bsel = amt_w; ill = !HAS_SHIFT; end
      6'h05, 6'h25: begin op = ALU_SR;  bsel = amt_w; ill = !HAS_SHIFT && (amt != SHW'(1)); end
      6'h00, 6'h20: begin op = ALU_SRU; bsel = amt_w; ill = !HAS_SHIFT && (amt != SHW'(1)); end
      6'h02, 6'h22: begin op = ALU_MUL;   ill = !HAS_MUL;  end
      6'h2C:        begin op = ALU_SEXTB; ill = !HAS_SEXT; end
      6'h37:        begin op = ALU_SEXTH; ill = !HAS_SEXT; end
      6'h23, 6'h31: begin
        op = (opc == 6'h23) ? ALU_DIV : ALU_MOD;
        if (!HAS_DIV) ill = 1'b1;
        else if (opb == '0) dz = 1'b1;
      end
      6'h27, 6'h2A, 6'h33, 6'h35: ill = 1'b1;
      6'h03, 6'h04, 6'h07, 6'h0A, 6'h0B, 6'h0C, 6'h10, 6'h11, 6'h12, 6'h13,
      6'h14, 6'h15, 6'h16, 6'h17, 6'h24, 6'h2B, 6'h30, 6'h34, 6'h36, 6'h38,
      6'h3E:        ho = 1'b1;
      default:      ill = 1'b1;
    endcase
    dec.opnd_b  = bsel;
    dec.dest    = dst;
    dec.illegal = ill;
    dec.dz      = dz;
    dec.halt    = hlt;
    dec.handoff = ho;
    dec.op      = (ill || hlt || ho || dz) ? ALU_NOP : op;
    dec.wr      = !(ill || hlt || ho || dz) && (op != ALU_NOP) && (dst != '0);
    dec.div     = !(ill || dz) && ((op == ALU_DIV) || (op == ALU_MOD));
  end
endmodule

// File: rtl/iexc_alu.sv
module iexc_alu
  import iexc_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  logic [SHW-1:0] sh;
  logic           flag;

  always_comb begin
    sh   = b[SHW-1:0];
    flag = 1'b0;
    y    = '0;
    case (op)
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_AND:   y = a & b;
      ALU_OR:    y = a | b;
      ALU_XOR:   y = a ^ b;
      ALU_NOR:   y = ~(a | b);
      ALU_XNOR:  y = ~(a ^ b);
      ALU_SL:    y = a << sh;
      ALU_SR:    y = $unsigned($signed(a) >>> sh);
      ALU_SRU:   y = a >> sh;
      ALU_MUL:   y = a * b;
      ALU_SEXTB: y = {{(XLEN-8){a[7]}}, a[7:0]};
      ALU_SEXTH: y = {{(XLEN-16){a[15]}}, a[15:0]};
      ALU_CEQ:   flag = (a == b);
      ALU_CNE:   flag = (a != b);
      ALU_CGT:   flag = ($signed(a) > $signed(b));
      ALU_CGE:   flag = ($signed(a) >= $signed(b));
      ALU_CGTU:  flag = (a > b);
      ALU_CGEU:  flag = (a >= b);
      default:   y = '0;
    endcase
    if (op inside {ALU_CEQ, ALU_CNE, ALU_CGT, ALU_CGE, ALU_CGTU, ALU_CGEU})
      y = {{(XLEN-1){1'b0}}, flag};
  end
endmodule

// File: rtl/iexc_divider.sv
module iexc_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         want_rem,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] res
);
  localparam int CW = $clog2(W);

  logic          busy_q, busy_n, mod_q, mod_n, neg;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [W-1:0]  rem_q, rem_n, quo_q, quo_n, dvs_q, dvs_n, rem_step, quo_step;
  logic [W:0]    shifted;
  logic [W+1:0]  diff;

  always_comb begin
    busy_n = busy_q; cnt_n = cnt_q; rem_n = rem_q;
    quo_n  = quo_q;  dvs_n = dvs_q; mod_n = mod_q;
    shifted  = {rem_q, quo_q[W-1]};
    diff     = {1'b0, shifted} - {2'b00, dvs_q};
    neg      = diff[W+1];
    rem_step = neg ? shifted[W-1:0] : diff[W-1:0];
    quo_step = {quo_q[W-2:0], ~neg};
    fin      = busy_q && (cnt_q == CW'(W-1));
    res      = mod_q ? rem_step : quo_step;
    if (start && !busy_q) begin
      busy_n = 1'b1; cnt_n = '0; rem_n = '0;
      quo_n  = dividend; dvs_n = divisor; mod_n = want_rem;
    end else if (busy_q) begin
      rem_n = rem_step; quo_n = quo_step; cnt_n = cnt_q + 1'b1;
      if (fin) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; cnt_q <= '0; rem_q <= '0;
      quo_q  <= '0;   dvs_q <= '0; mod_q <= 1'b0;
    end else begin
      busy_q <= busy_n; cnt_q <= cnt_n; rem_q <= rem_n;
      quo_q  <= quo_n;  dvs_q <= dvs_n; mod_q <= mod_n;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/int_exec_core.sv
module int_exec_core
  import iexc_pkg::*;
#(
  parameter bit HAS_MUL   = 1'b1,
  parameter bit HAS_DIV   = 1'b1,
  parameter bit HAS_SEXT  = 1'b1,
  parameter bit HAS_SHIFT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            done,
  output logic            busy,
  output logic [XLEN-1:0] result,
  output logic [RIDX-1:0] dest,
  output logic            wr_en,
  output logic            illegal,
  output logic            div_zero,
  output logic            halt,
  output logic            handoff
);
  logic [1:0]      rsync;
  logic            rst_core_n;
  dec_t            dec;
  logic [XLEN-1:0] alu_y, div_res;
  logic            div_busy, div_fin, accept, single, div_go;
  logic            done_q, wr_q, ill_q, dz_q, halt_q, ho_q, pend_wr_q;
  logic [XLEN-1:0] res_q;
  logic [RIDX-1:0] dest_q, pend_dest_q;
  logic            done_n, wr_n, ill_n, dz_n, halt_n, ho_n;
  logic [XLEN-1:0] res_n;
  logic [RIDX-1:0] dest_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= '0;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_core_n = rsync[1];

  iexc_decode #(.HAS_MUL(HAS_MUL), .HAS_DIV(HAS_DIV), .HAS_SEXT(HAS_SEXT),
                .HAS_SHIFT(HAS_SHIFT))
    u_dec (.instr(instr), .opb(opb), .dec(dec));

  iexc_alu u_alu (.op(dec.op), .a(opa), .b(dec.opnd_b), .y(alu_y));

  iexc_divider #(.W(XLEN)) u_div (
    .clk(clk), .rst_n(rst_core_n), .start(div_go), .dividend(opa),
    .divisor(opb), .want_rem(dec.op == ALU_MOD), .busy(div_busy),
    .fin(div_fin), .res(div_res));

  assign accept = issue_valid && !div_busy;
  assign single = accept && !dec.div;
  assign div_go = accept && dec.div;

  always_comb begin
    done_n = single || div_fin;
    res_n  = div_fin ? div_res : alu_y;
    dest_n = div_fin ? pend_dest_q : dec.dest;
    wr_n   = div_fin ? pend_wr_q : (single && dec.wr);
    ill_n  = single && dec.illegal;
    dz_n   = single && dec.dz;
    halt_n = single && dec.halt;
    ho_n   = single && dec.handoff;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      done_q <= 1'b0; wr_q <= 1'b0; ill_q <= 1'b0; dz_q <= 1'b0;
      halt_q <= 1'b0; ho_q <= 1'b0; res_q <= '0; dest_q <= '0;
      pend_dest_q <= '0; pend_wr_q <= 1'b0;
    end else begin
      done_q <= done_n; wr_q <= wr_n; ill_q <= ill_n; dz_q <= dz_n;
      halt_q <= halt_n; ho_q <= ho_n;
      if (done_n) begin
        res_q  <= res_n;
        dest_q <= dest_n;
      end
      if (div_go) begin
        pend_dest_q <= dec.dest;
        pend_wr_q   <= dec.wr;
      end
    end
  end

  assign done = done_q;  assign busy = div_busy; assign result = res_q;
  assign dest = dest_q;  assign wr_en = wr_q;    assign illegal = ill_q;
  assign div_zero = dz_q; assign halt = halt_q;  assign handoff = ho_q;
endmodule

// File: rtl/iexc_checker.sv
module iexc_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        done,
  input logic        busy,
  input logic [4:0]  dest,
  input logic        wr_en,
  input logic        illegal,
  input logic        div_zero,
  input logic        halt,
  input logic        handoff
);
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R9
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R9
  AST_NO_REG0_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (dest != 5'd0)); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot0({wr_en, illegal, div_zero, halt, handoff})); // R11
  AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || illegal || div_zero || halt || handoff) |-> done); // R14
endmodule

bind int_exec_core iexc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .busy(busy), .dest(dest),
  .wr_en(wr_en), .illegal(illegal), .div_zero(div_zero), .halt(halt),
  .handoff(handoff));

// File: tb/sim_int_exec_core.sv
`timescale 1ns/1ps
module sim_int_exec_core;
  logic clk, rst_n, iv;
  logic [31:0] ins, a, b;
  logic        o_done [2], o_busy [2], o_wr [2], o_ill [2], o_dz [2], o_hlt [2], o_ho [2];
  logic [31:0] o_res [2];
  logic [4:0]  o_dst [2];
  int errors = 0, checks = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int_exec_core u0 (.clk(clk), .rst_n(rst_n), .issue_valid(iv), .instr(ins), .opa(a), .opb(b),
    .done(o_done[0]), .busy(o_busy[0]), .result(o_res[0]), .dest(o_dst[0]), .wr_en(o_wr[0]),
    .illegal(o_ill[0]), .div_zero(o_dz[0]), .halt(o_hlt[0]), .handoff(o_ho[0]));

  int_exec_core #(.HAS_MUL(1'b0), .HAS_DIV(1'b0), .HAS_SEXT(1'b0), .HAS_SHIFT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .issue_valid(iv), .instr(ins), .opa(a), .opb(b),
    .done(o_done[1]), .busy(o_busy[1]), .result(o_res[1]), .dest(o_dst[1]), .wr_en(o_wr[1]),
    .illegal(o_ill[1]), .div_zero(o_dz[1]), .halt(o_hlt[1]), .handoff(o_ho[1]));

  typedef struct {
    logic [31:0] res; logic [4:0] dst;
    bit wr, ill, dz, hlt, ho, dv; string tag;
  } exp_t;

  function automatic exp_t model(bit full, logic [31:0] w, logic [31:0] x, logic [31:0] y);
    exp_t e;
    bit rr = w[31];
    logic [31:0] sx = {{16{w[15]}}, w[15:0]};
    logic [31:0] zx = {16'h0, w[15:0]};
    logic [31:0] hi = {w[15:0], 16'h0};
    logic [31:0] bs = rr ? y : sx;
    logic [31:0] bz = rr ? y : zx;
    int amt = rr ? int'(y[4:0]) : int'(w[4:0]);
    e.res = 0; e.dst = rr ? w[15:11] : w[20:16];
    e.ill = 0; e.dz = 0; e.hlt = 0; e.ho = 0; e.dv = 0; e.tag = "R3";
    case (w[31:26])
      6'h0D, 6'h2D: e.res = x + bs;
      6'h32: e.res = x - y;
      6'h08: e.res = x & zx;
      6'h28: if (w[25:11] == 0) begin e.hlt = 1; e.tag = "R12"; end else e.res = x & y;
      6'h0E, 6'h2E: e.res = x | bz;
      6'h06, 6'h26: e.res = x ^ bz;
      6'h01, 6'h21: e.res = ~(x | bz);
      6'h09, 6'h29: e.res = ~(x ^ bz);
      6'h18: begin e.res = x & hi; e.tag = "R4"; end
      6'h1E: begin e.res = x | hi; e.tag = "R4"; end
      6'h19, 6'h39: begin e.res = (x == bs) ? 1 : 0; e.tag = "R5"; end
      6'h1F, 6'h3F: begin e.res = (x != bs) ? 1 : 0; e.tag = "R5"; end
      6'h1A, 6'h3A: begin e.res = ($signed(x) > $signed(bs)) ? 1 : 0; e.tag = "R5"; end
      6'h1B, 6'h3B: begin e.res = ($signed(x) >= $signed(bs)) ? 1 : 0; e.tag = "R5"; end
      6'h1D, 6'h3D: begin e.res = (x > bz) ? 1 : 0; e.tag = "R5"; end
      6'h1C, 6'h3C: begin e.res = (x >= bz) ? 1 : 0; e.tag = "R5"; end
      6'h0F, 6'h2F: if (!full) begin e.ill = 1; e.tag = "R7"; end
                    else begin e.res = x << amt; e.tag = "R6"; end
      6'h05, 6'h25: if (!full && amt != 1) begin e.ill = 1; e.tag = "R7"; end
                    else begin e.res = $unsigned($signed(x) >>> amt); e.tag = "R6"; end
      6'h00, 6'h20: if (!full && amt != 1) begin e.ill = 1; e.tag = "R7"; end
                    else begin e.res = x >> amt; e.tag = "R6"; end
      6'h02, 6'h22: begin e.tag = "R8"; if (!full) e.ill = 1; else e.res = x * bs; end
      6'h2C: begin e.tag = "R8"; if (!full) e.ill = 1; else e.res = {{24{x[7]}}, x[7:0]}; end
      6'h37: begin e.tag = "R8"; if (!full) e.ill = 1; else e.res = {{16{x[15]}}, x[15:0]}; end
      6'h23, 6'h31: begin
        if (!full) begin e.ill = 1; e.tag = "R10"; end
        else if (y == 0) begin e.dz = 1; e.tag = "R10"; end
        else begin e.dv = 1; e.tag = "R9"; e.res = (w[31:26] == 6'h23) ? x / y : x % y; end
      end
      6'h27, 6'h2A, 6'h33, 6'h35: begin e.ill = 1; e.tag = "R11"; end
      default: begin e.ho = 1; e.tag = "R13"; end
    endcase
    e.wr = !(e.ill || e.dz || e.hlt || e.ho) && (e.dst != 0);
    if (!(e.ill || e.dz || e.hlt || e.ho) && e.dst == 0) e.tag = "R2";
    return e;
  endfunction

  int   cnt [2];
  bit   edone [2];
  exp_t pend [2], cur [2];
  bit   rst_phase;

  task automatic step();
    @(posedge clk);
    for (int i = 0; i < 2; i++) begin
      edone[i] = 0;
      if (!rst_n) cnt[i] = 0;
      else if (cnt[i] > 0) begin
        cnt[i]--;
        if (cnt[i] == 0) begin edone[i] = 1; cur[i] = pend[i]; end
      end else if (iv) begin
        exp_t e = model(i == 0, ins, a, b);
        if (e.dv) begin cnt[i] = 32; pend[i] = e; end
        else begin edone[i] = 1; cur[i] = e; end
      end
    end
    #1;
    for (int i = 0; i < 2; i++) begin
      bit ok;
      string tag;
      tag = rst_phase ? "R1" : (edone[i] ? cur[i].tag : (cnt[i] > 0 ? "R9" : "R14"));
      ok = (o_done[i] == edone[i]) && (o_busy[i] == (cnt[i] > 0));
      if (edone[i]) begin
        ok = ok && o_wr[i] == cur[i].wr && o_ill[i] == cur[i].ill && o_dz[i] == cur[i].dz
                && o_hlt[i] == cur[i].hlt && o_ho[i] == cur[i].ho;
        if (cur[i].wr) ok = ok && o_res[i] == cur[i].res && o_dst[i] == cur[i].dst;
      end else
        ok = ok && !o_wr[i] && !o_ill[i] && !o_dz[i] && !o_hlt[i] && !o_ho[i];
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL %s u%0d t=%0t ins=%h: actual done=%0b busy=%0b res=%h dst=%0d wr=%0b ill=%0b dz=%0b hlt=%0b ho=%0b expected done=%0b busy=%0b res=%h dst=%0d wr=%0b ill=%0b dz=%0b hlt=%0b ho=%0b",
          tag, i, $time, ins, o_done[i], o_busy[i], o_res[i], o_dst[i], o_wr[i], o_ill[i], o_dz[i],
          o_hlt[i], o_ho[i], edone[i], cnt[i] > 0, cur[i].res, cur[i].dst, cur[i].wr && edone[i],
          cur[i].ill && edone[i], cur[i].dz && edone[i], cur[i].hlt && edone[i], cur[i].ho && edone[i]);
      end
    end
  endtask

  function automatic logic [31:0] fri(logic [5:0] op, logic [4:0] r0, logic [4:0] r1, logic [15:0] im);
    return {op, r0, r1, im};
  endfunction
  function automatic logic [31:0] frr(logic [5:0] op, logic [4:0] r0, logic [4:0] r1, logic [4:0] r2);
    return {op, r0, r1, r2, 11'h0};
  endfunction

  task automatic issue(logic [31:0] w, logic [31:0] x, logic [31:0] y);
    iv = 1; ins = w; a = x; b = y;
    step();
    iv = 0;
  endtask

  task automatic idle(int n);
    iv = 0;
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R14 watchdog: actual=still running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cnt[0] = 0; cnt[1] = 0;
    rst_n = 1'b0; iv = 0; ins = 0; a = 0; b = 0; rst_phase = 1;
    // R1: reset state, then the idle cycles before the first issue
    idle(3);
    rst_n = 1'b1;
    idle(4);
    rst_phase = 0;
    // R3 arithmetic and logic, both forms
    issue(fri(6'h0D, 1, 2, 16'hFFFF), 32'd5, 0);
    issue(frr(6'h2D, 1, 2, 3), 32'h7FFF_FFFF, 32'd1);
    issue(frr(6'h32, 1, 2, 4), 32'd3, 32'd10);
    issue(fri(6'h08, 1, 2, 16'h8F0F), 32'hFFFF_FFFF, 0);
    issue(fri(6'h0E, 1, 2, 16'h8000), 32'h1, 0);
    issue(fri(6'h06, 1, 2, 16'hFFFF), 32'hAAAA_AAAA, 0);
    issue(fri(6'h01, 1, 2, 16'h00FF), 32'h0F00_0000, 0);
    issue(frr(6'h29, 1, 2, 7), 32'h1234_5678, 32'h1234_0000);
    // R4 high-half forms
    issue(fri(6'h18, 1, 2, 16'hF0F0), 32'hFFFF_FFFF, 0);
    issue(fri(6'h1E, 1, 2, 16'h8001), 32'h0000_1234, 0);
    // R5 compares: signed vs unsigned immediate extension
    issue(fri(6'h1A, 1, 2, 16'hFFFF), 32'd0, 0);
    issue(fri(6'h1D, 1, 2, 16'hFFFF), 32'd0, 0);
    issue(fri(6'h1C, 1, 2, 16'hFFFF), 32'h0001_0000, 0);
    issue(frr(6'h3B, 1, 2, 5), 32'h8000_0000, 32'd1);
    issue(frr(6'h39, 1, 2, 5), 32'd9, 32'd9);
    issue(fri(6'h1F, 1, 2, 16'd9), 32'd9, 0);
    // R6 / R7 shifts, amount 1 and others
    issue(frr(6'h2F, 1, 2, 6), 32'h0000_0003, 32'hFFFF_FF25);
    issue(frr(6'h25, 1, 2, 6), 32'h8000_0010, 32'd1);
    issue(fri(6'h05, 1, 2, 16'd4), 32'h8000_0010, 0);
    issue(fri(6'h00, 1, 2, 16'd1), 32'h8000_0010, 0);
    issue(frr(6'h20, 1, 2, 6), 32'h8000_0010, 32'd3);
    // R8 multiply and sign extension
    issue(fri(6'h02, 1, 2, 16'hFFFE), 32'd7, 0);
    issue(frr(6'h2C, 1, 0, 3), 32'h0000_0080, 0);
    issue(frr(6'h37, 1, 0, 3), 32'h0000_7FFF, 0);
    // R9 divide with an instruction held on the inputs during the whole run
    iv = 1; ins = frr(6'h23, 1, 2, 3); a = 32'd1000; b = 32'd7;
    step();
    ins = fri(6'h0D, 1, 9, 16'd1); a = 32'd41;
    for (int k = 0; k < 34; k++) step();
    iv = 0;
    issue(frr(6'h31, 1, 2, 3), 32'hFFFF_FFFF, 32'd10);
    idle(33);
    // R10 divide by zero
    issue(frr(6'h23, 1, 2, 3), 32'd5, 32'd0);
    // R11 illegal opcodes
    issue(frr(6'h27, 1, 2, 3), 1, 1);
    issue(frr(6'h2A, 1, 2, 3), 1, 1);
    issue(frr(6'h33, 1, 2, 3), 1, 1);
    issue(frr(6'h35, 1, 2, 3), 1, 1);
    // R12 halt and the ordinary and beside it
    issue(frr(6'h28, 0, 0, 0), 32'h5, 32'h3);
    issue(frr(6'h28, 0, 1, 0), 32'h5, 32'h3);
    issue(frr(6'h28, 0, 1, 4), 32'h5, 32'h3);
    // R13 hand-off
    issue(fri(6'h04, 1, 2, 0), 0, 0);
    issue(fri(6'h16, 1, 2, 0), 0, 0);
    issue(frr(6'h34, 1, 2, 3), 0, 0);
    issue(frr(6'h3E, 1, 2, 3), 0, 0);
    // R2 write to register 0 suppressed
    issue(fri(6'h0D, 1, 0, 16'd3), 32'd4, 0);
    // R14 back-to-back single-cycle ops
    for (int k = 0; k < 20; k++) begin
      iv = 1; ins = fri(6'h0D, 2, 5, 16'(k)); a = k; b = 0;
      step();
    end
    iv = 0;
    // random mix
    for (int k = 0; k < 2500; k++) begin
      iv = ($urandom % 4) != 0;
      ins = $urandom; a = $urandom;
      b = (($urandom % 3) == 0) ? ($urandom % 3) : $urandom;
      step();
    end
    iv = 0;
    idle(40);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule